// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block owns the refresh duty of a fast page mode DRAM array. After reset it holds off all traffic for a power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `init_done_o`. An external arbiter must keep host accesses blocked until that signal is high. From then on an interval timer spaces refreshes so that every row is visited within the retention window. The interval is the window length divided by the row count.

The sequencer shares the DRAM control pins with the access controller. It asks for them with `req_o`. It starts a refresh only in a cycle where `gnt_i` is high, and it keeps `req_o` high for the whole refresh. The arbiter is expected to keep the grant while `req_o` stays high. A build parameter selects the refresh style:
- CAS-before-RAS: the address bus is left at zero.
- Row-addressed RAS-only: an internal row counter supplies the address and advances after each refresh.

Refresh ticks that arrive while the grant is withheld are counted, up to a limit. A tick that finds the counter full sets a sticky error flag.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, `addr_o` is 0, and `req_o`, `init_done_o` and `ovf_o` are 0.
- R2: `req_o` first rises between PWRUP_CYC and PWRUP_CYC+1 cycles after reset is released.
- R3: Exactly WARMUP refresh cycles run before `init_done_o` rises. It is still 0 when the last warm-up cycle lowers RAS, and once high it stays high.
- R4: While `req_o` is 0, `ras_n_o` and `cas_n_o` are 1 and `addr_o` is 0. A refresh starts only in a cycle where `gnt_i` is 1.
- R5: In CAS-before-RAS mode (MODE=RFSH_CBR, encoded 0):
  - CAS is low for at least T_CSR cycles before the cycle in which RAS falls.
  - CAS stays low for at least T_CHR cycles counted from the RAS fall.
  - CAS is back high when RAS rises.
  - `we_n_o` is always 1.
- R6: In RAS-only mode (MODE=RFSH_ROW, encoded 1), CAS stays high. The row address is on `addr_o` at least one cycle before RAS falls and is stable while RAS is low.
- R7: RAS stays low for exactly T_RAS cycles per refresh. Between refreshes it stays high for at least T_RP cycles. Successive RAS falls are at least T_RC cycles apart.
- R8: In RAS-only mode, successive refreshes address rows 0, 1, … ROWS-1, then wrap to row 0.
- R9: After initialization, with the grant freely given, one refresh runs per interval. Successive RAS falls are exactly REF_WIN_CYC/ROWS cycles apart.
- R10: While the grant is withheld, up to MAX_PEND ticks are kept and `req_o` stays high. When the grant returns, exactly that many refreshes run back to back, and then `req_o` drops.
- R11: A tick that arrives with MAX_PEND refreshes already pending sets `ovf_o`. `ovf_o` is 0 before that tick and stays 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gnt_i | input | 1 | Arbiter grant of the DRAM pins |
| req_o | output | 1 | Request for the DRAM pins, held for the whole refresh |
| init_done_o | output | 1 | Pause and warm-up finished; host accesses may begin |
| ovf_o | output | 1 | Sticky flag: a refresh tick was lost |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | clog2(ROWS) | Row address for RAS-only refresh, otherwise 0 |

## Verification
The hardest state to reach is a full pending counter followed by one more tick. This needs the grant withheld across MAX_PEND+1 timer intervals. The stimulus drops the grant right after an observed RAS fall, when the backlog is known to be empty. It then samples half an interval after the fourth tick and again after the fifth, so each sample lands well away from any tick. The grant is then returned. The bench counts the RAS falls in the drain burst and confirms that the row sequence continues without a gap across the wrap.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic {RFSH_CBR = 1'b0, RFSH_ROW = 1'b1} rfsh_mode_e;
endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int INTERVAL = 3125,
  parameter int MAX_PEND = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dec_i,
  output logic pend_o,
  output logic ovf_o
);
  localparam int CNT_W  = $clog2(INTERVAL + 1);
  localparam int PEND_W = $clog2(MAX_PEND + 1);
  localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(INTERVAL - 1);
  localparam logic [PEND_W-1:0] FULL_P = PEND_W'(MAX_PEND);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              ovf_q, tick;

  assign tick = en_i && (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick, dec_i})
        2'b10:   if (pend_q == FULL_P) ovf_q <= 1'b1;
                 else pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0) pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pend_o = (pend_q != '0);
  assign ovf_o  = ovf_q;

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_q |=> ovf_q);
  // R10
  pend_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_q <= FULL_P);
endmodule

// File: rtl/dram_rfsh_cycle.sv
module dram_rfsh_cycle
  import dram_rfsh_pkg::*;
#(
  parameter rfsh_mode_e MODE = RFSH_CBR,
  parameter int ROW_W = 12,
  parameter int T_CSR = 2,
  parameter int T_CHR = 2,
  parameter int T_RAS = 10,
  parameter int T_RP  = 6,
  parameter int T_RC  = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int LEAD    = (MODE == RFSH_CBR) ? T_CSR : 1;
  localparam int TOT_RAW = LEAD + T_RAS + T_RP;
  localparam int TOT     = (TOT_RAW > T_RC) ? TOT_RAW : T_RC;
  localparam int T_W     = $clog2(TOT + 1);
  localparam logic [T_W-1:0] LEAD_T    = T_W'(LEAD);
  localparam logic [T_W-1:0] RAS_END_T = T_W'(LEAD + T_RAS);
  localparam logic [T_W-1:0] CAS_END_T = T_W'(LEAD + T_CHR);
  localparam logic [T_W-1:0] LAST_T    = T_W'(TOT - 1);

  logic             busy_q, ras_q, cas_q, cas_d;
  logic [T_W-1:0]   t_q;
  logic [ROW_W-1:0] addr_q, addr_d;

  generate
    if (MODE == RFSH_CBR) begin : g_cbr
      assign cas_d  = !(busy_q && (t_q < CAS_END_T));
      assign addr_d = '0;
    end else begin : g_row
      assign cas_d  = 1'b1;
      assign addr_d = (busy_q && (t_q < RAS_END_T)) ? row_i : '0;
    end
  endgenerate

  // pins are registered from the phase counter: one cycle behind it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      addr_q <= '0;
    end else begin
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          t_q    <= '0;
        end
      end else if (t_q == LAST_T) busy_q <= 1'b0;
      else t_q <= t_q + 1'b1;
      ras_q  <= !(busy_q && (t_q >= LEAD_T) && (t_q < RAS_END_T));
      cas_q  <= cas_d;
      addr_q <= addr_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = busy_q && (t_q == LAST_T);
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;
  assign addr_o  = addr_q;

  generate
    if (MODE == RFSH_CBR) begin : g_cbr_chk
      // R5
      cas_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ras_q) |-> (!cas_q && $past(!cas_q)));
      // R5
      cas_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ras_q) |-> cas_q);
    end else begin : g_row_chk
      // R6
      row_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_q |-> cas_q);
      // R6
      row_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ras_q && !$past(ras_q)) |-> $stable(addr_q));
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter rfsh_mode_e MODE = RFSH_CBR,
  parameter int ROWS        = 4096,
  parameter int REF_WIN_CYC = 12_800_000,
  parameter int PWRUP_CYC   = 40_000,
  parameter int WARMUP      = 8,
  parameter int MAX_PEND    = 4,
  parameter int T_CSR       = 2,
  parameter int T_CHR       = 2,
  parameter int T_RAS       = 10,
  parameter int T_RP        = 6,
  parameter int T_RC        = 18,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             init_done_o,
  output logic             ovf_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int INTERVAL = REF_WIN_CYC / ROWS;
  localparam int PW_W     = $clog2(PWRUP_CYC + 1);
  localparam int WARM_W   = $clog2(WARMUP + 1);

  logic [PW_W-1:0]   pwr_cnt_q;
  logic              pwr_done_q;
  logic [WARM_W-1:0] warm_q;
  logic [ROW_W-1:0]  row_q;
  logic              busy, done, pend, need, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_cnt_q  <= '0;
      pwr_done_q <= 1'b0;
    end else if (!pwr_done_q) begin
      if (pwr_cnt_q == PW_W'(PWRUP_CYC - 1)) pwr_done_q <= 1'b1;
      else pwr_cnt_q <= pwr_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= WARM_W'(WARMUP);
    else if (done && (warm_q != '0)) warm_q <= warm_q - 1'b1;
  end

  generate
    if (MODE == RFSH_ROW) begin : g_rowcnt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row_q <= '0;
        else if (done) row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end
    end else begin : g_norow
      assign row_q = '0;
    end
  endgenerate

  assign init_done_o = pwr_done_q && (warm_q == '0);
  assign need        = pwr_done_q && ((warm_q != '0) || pend);
  assign req_o       = need || busy;
  assign start       = need && gnt_i && !busy;
  assign we_n_o      = 1'b1;

  dram_rfsh_timer #(.INTERVAL(INTERVAL), .MAX_PEND(MAX_PEND)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .dec_i  (done && (warm_q == '0)),
    .pend_o (pend),
    .ovf_o  (ovf_o)
  );

  dram_rfsh_cycle #(
    .MODE(MODE), .ROW_W(ROW_W), .T_CSR(T_CSR), .T_CHR(T_CHR),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
  ) u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .row_i   (row_q),
    .busy_o  (busy),
    .done_o  (done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .addr_o  (addr_o)
  );

  // R4
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (ras_n_o && cas_n_o && (addr_o == '0)));
  // R4
  grant_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(gnt_i));
  // R3
  init_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  // R2
  pwr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done_q |-> (!req_o && ras_n_o));
endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/100ps
module dram_refresh_seq_tb;
  import dram_rfsh_pkg::*;
  localparam int ROWS = 8, WIN = 3200, PWR = 50, WARM = 8, MAXP = 4;
  localparam int TCSR = 2, TCHR = 2, TRAS = 10, TRP = 6, TRC = 18;
  localparam int IVL = WIN / ROWS;

  logic clk = 0, rst_n = 0, auto_gnt = 0;
  always #2.5 clk = ~clk;

  logic req_a, init_a, ovf_a, ras_a, cas_a, we_a;
  logic req_b, init_b, ovf_b, ras_b, cas_b, we_b;
  logic [2:0] addr_a, addr_b;
  logic gnt_a, gnt_b;
  assign gnt_a = auto_gnt & req_a;
  assign gnt_b = auto_gnt & req_b;

  dram_refresh_seq #(.MODE(RFSH_ROW), .ROWS(ROWS), .REF_WIN_CYC(WIN), .PWRUP_CYC(PWR),
    .WARMUP(WARM), .MAX_PEND(MAXP), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS),
    .T_RP(TRP), .T_RC(TRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_a), .req_o(req_a), .init_done_o(init_a),
    .ovf_o(ovf_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a), .addr_o(addr_a));

  dram_refresh_seq #(.MODE(RFSH_CBR), .ROWS(ROWS), .REF_WIN_CYC(WIN), .PWRUP_CYC(PWR),
    .WARMUP(WARM), .MAX_PEND(MAXP), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS),
    .T_RP(TRP), .T_RC(TRC)) u_dut_cbr (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_b), .req_o(req_b), .init_done_o(init_b),
    .ovf_o(ovf_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b), .addr_o(addr_b));

  int total = 0, bad = 0, cyc = 0;
  int r4_err = 0, r5_err = 0, r6_err = 0;
  logic [2:0] exp_q[$];
  int next_row = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: push the row sequence the next n refreshes must carry
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(3'(next_row));
      next_row = (next_row + 1) % ROWS;
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // monitor for the RAS-only instance
  logic prev_ras_a = 1;
  logic [2:0] prev_addr_a = 0;
  int falls_a = 0, low_a = 0, high_a = 0, last_fall_a = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!req_a && (!ras_a || !cas_a || addr_a != 0)) r4_err++;
      if (!req_b && (!ras_b || !cas_b)) r4_err++;
      if (!ras_a && cas_a !== 1'b1) r6_err++;
      if (!ras_a && !prev_ras_a && addr_a != prev_addr_a) r6_err++;
      if (prev_ras_a && !ras_a) begin
        if (falls_a > 0) begin
          chk(cyc - last_fall_a >= TRC, "R7 fall-to-fall", cyc - last_fall_a, TRC);
          chk(high_a >= TRP, "R7 precharge", high_a, TRP);
        end
        if (falls_a >= 9 && falls_a <= 11)
          chk(cyc - last_fall_a == IVL, "R9 interval", cyc - last_fall_a, IVL);
        chk(addr_a == prev_addr_a, "R6 address setup", addr_a, prev_addr_a);
        if (exp_q.size() == 0) chk(0, "R8 unexpected refresh", addr_a, -1);
        else begin
          automatic logic [2:0] e = exp_q.pop_front();
          chk(addr_a == e, "R8 row", addr_a, e);
        end
        last_fall_a = cyc;
        falls_a++;
        low_a = 0;
        high_a = 0;
      end
      if (!prev_ras_a && ras_a) chk(low_a == TRAS, "R7 ras width", low_a, TRAS);
      if (!ras_a) low_a++; else high_a++;
    end
    prev_ras_a = ras_a;
    prev_addr_a = addr_a;
  end

  // monitor for the CAS-before-RAS instance
  logic prev_ras_b = 1, hold_on = 0;
  int falls_b = 0, low_b = 0, cas_run = 0, cas_after = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (we_b !== 1'b1) r5_err++;
      if (!cas_b) cas_run++; else cas_run = 0;
      if (prev_ras_b && !ras_b) begin
        chk(cas_run - 1 >= TCSR, "R5 cas setup", cas_run - 1, TCSR);
        cas_after = cas_b ? 0 : 1;
        hold_on = !cas_b;
        falls_b++;
        low_b = 0;
      end else if (!ras_b && hold_on) begin
        if (!cas_b) cas_after++; else hold_on = 0;
      end
      if (!prev_ras_b && ras_b) begin
        chk(cas_after >= TCHR, "R5 cas hold", cas_after, TCHR);
        chk(cas_b, "R5 cas high at ras rise", cas_b, 1);
        chk(low_b == TRAS, "R7 ras width cbr", low_b, TRAS);
        hold_on = 0;
      end
      if (!ras_b) low_b++;
    end
    prev_ras_b = ras_b;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, f0, n0;
    repeat (3) step();
    // R1
    chk(ras_a && cas_a && we_a && addr_a == 0, "R1 pins in reset", {ras_a, cas_a, we_a}, 7);
    chk(!req_a && !init_a && !ovf_a, "R1 status in reset", {req_a, init_a, ovf_a}, 0);
    chk(ras_b && cas_b && we_b && !req_b && !init_b && !ovf_b, "R1 cbr reset",
        {ras_b, cas_b, we_b, req_b, init_b, ovf_b}, 56);
    push_rows(WARM);
    auto_gnt = 1;
    @(negedge clk);
    rst_n = 1;
    c = 0;
    while (!req_a && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk(c >= PWR && c <= PWR + 1, "R2 power-up pause", c, PWR);
    while (falls_a < WARM) step();
    chk(!init_a, "R3 init_done early", init_a, 0);
    c = 0;
    while (!init_a && c < 200) begin
      step();
      c++;
    end
    chk(init_a && init_b, "R3 init_done", {init_a, init_b}, 3);
    chk(falls_a == WARM, "R3 warm-up count", falls_a, WARM);
    // steady state, includes row wrap (R8)
    push_rows(4);
    while (falls_a < WARM + 4) step();
    chk(init_a, "R3 init_done held", init_a, 1);
    f0 = cyc;
    auto_gnt = 0;
    repeat (4 * IVL + IVL / 2) step();
    chk(!ovf_a && !ovf_b, "R11 no overflow at full backlog", {ovf_a, ovf_b}, 0);
    chk(req_a, "R10 request held", req_a, 1);
    chk(falls_a == WARM + 4, "R4 no refresh without grant", falls_a, WARM + 4);
    repeat (IVL) step();
    chk(ovf_a && ovf_b, "R11 overflow flagged", {ovf_a, ovf_b}, 3);
    push_rows(MAXP);
    n0 = falls_a;
    auto_gnt = 1;
    repeat (150) step();
    chk(falls_a - n0 == MAXP, "R10 drained refreshes", falls_a - n0, MAXP);
    chk(!req_a, "R10 request released", req_a, 1'b0);
    chk(ovf_a, "R11 overflow sticky", ovf_a, 1);
    chk(exp_q.size() == 0, "R8 rows left", exp_q.size(), 0);
    chk(falls_b == falls_a, "R5 cbr refresh count", falls_b, falls_a);
    chk(r4_err == 0, "R4 idle pins", r4_err, 0);
    chk(r5_err == 0, "R5 write enable high", r5_err, 0);
    chk(r6_err == 0, "R6 cas high and address stable", r6_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    if (f0 < 0) $display("unreachable");
    $finish;
  end
endmodule